// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the even parity bit of a 32-bit PCI agent. Each address or data phase covers 36 bits: the 32 address/data lines and the 4 command/byte-enable lines. The parity bit is chosen so that the 37 bits together hold an even number of ones. When the agent drives a phase, the block places the matching parity bit on its output in the clock that follows. When the agent receives a phase, the block reduces the 36 bits at the phase clock. It compares that result with the parity bit the sender presents one clock later, and it reports any mismatch one clock after the comparison.

A mismatch is routed by phase kind. A data-phase error raises the parity-error output. An address-phase error pulls the open-drain system-error line. Each output is qualified by its own enable from the configuration command register. A sticky flag records every detected mismatch, whatever the enables are, until software writes a one to clear it. The surrounding bus state machine provides the phase qualifier, the address/data tag and the direction select.

Top module: `pci_parity_unit`

## Requirements
- R1: When `phase_vld_i` and `drive_i` are both high at a clock edge, in the following cycle `par_oe_o` is 1 and `par_o` equals the XOR of all bits of `ad_i` and `cbe_i` sampled at that edge, so the 37 bits carry even parity.
- R2: After any edge at which `phase_vld_i && drive_i` is false, `par_oe_o` and `par_o` are both 0 in the following cycle.
- R3: A received phase (`phase_vld_i` high, `drive_i` low) sampled at edge N is compared with `par_i` sampled at edge N+1. A mismatch appears on the error outputs after edge N+2 and lasts exactly one cycle.
- R4: A mismatch on a data phase (`phase_is_addr_i` = 0) drives `perr_o` high only if `perr_en_i` is 1 at edge N+2. `serr_pull_o` stays low.
- R5: A mismatch on an address phase (`phase_is_addr_i` = 1) drives `serr_pull_o` high (meaning pull the open-drain line low) only if `serr_en_i` is 1 at edge N+2. `perr_o` stays low.
- R6: A received phase whose `par_i` matches the computed parity raises neither error output and does not set the sticky flag.
- R7: Phases the agent drives itself (`drive_i` high) are never checked, whatever `par_i` holds.
- R8: `par_err_o` goes to 1 at edge N+2 for any mismatch, regardless of both enables. It holds until an edge with `sticky_clr_i` = 1 and no new mismatch; a new mismatch at the same edge as the clear wins.
- R9: Received phases on consecutive clocks are checked independently, each reporting in its own cycle.
- R10: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_vld_i | input | 1 | An address or data phase is on the bus this cycle |
| phase_is_addr_i | input | 1 | 1: address phase, 0: data phase |
| drive_i | input | 1 | 1: this agent drives the phase, 0: it receives it |
| ad_i | input | 32 | Address/data lines |
| cbe_i | input | 4 | Command/byte-enable lines |
| par_i | input | 1 | Parity bit sampled from the bus |
| perr_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |
| sticky_clr_i | input | 1 | Write-one-to-clear of the sticky flag |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Drive enable for the parity bit |
| perr_o | output | 1 | Data parity error, one cycle per error |
| serr_pull_o | output | 1 | Pull request for the open-drain system error line |
| par_err_o | output | 1 | Sticky record of any detected parity error |

## Verification
Generated parity is due one cycle after the sending phase. The bench drives every input on the falling edge and reads `par_o` at the next falling edge. The check path is registered three times, so an error pulse is due at the third falling edge after the phase is applied. The bench reads it there and again one cycle later to confirm that the pulse is exactly one cycle wide. The sender's parity bit goes in at the first falling edge after the phase. In the back-to-back case this is the same cycle as the next phase, so the overlapping stages are exercised.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int unsigned AD_W   = 32;
  localparam int unsigned CBE_W  = 4;
  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic vld;
    logic is_addr;
  } ph_tag_t;
endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
  parameter int unsigned W      = 36,
  parameter int unsigned LANE_W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  localparam int unsigned NL = (W + LANE_W - 1) / LANE_W;
  localparam int unsigned PW = NL * LANE_W;

  logic [PW-1:0] pad;
  logic [NL-1:0] lane;

  assign pad = PW'(data_i);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane[g] = ^pad[g*LANE_W +: LANE_W];
  end

  assign par_o = ^lane;
endmodule

// File: rtl/pci_par_tx.sv
module pci_par_tx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic calc_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= send_i & calc_i;
      par_oe_o <= send_i;
    end
  end
endmodule

// File: rtl/pci_par_rx.sv
module pci_par_rx
  import pci_par_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ph_tag_t tag_i,
  input  logic    calc_i,
  input  logic    par_i,
  output ph_tag_t miss_o
);
  ph_tag_t lat_q;
  logic    calc_q;

  // stage A: latch local parity of the received phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      calc_q <= 1'b0;
    end else begin
      lat_q  <= tag_i;
      calc_q <= tag_i.vld & calc_i;
    end
  end

  // stage B: compare against sender parity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miss_o <= '0;
    end else begin
      miss_o.vld     <= lat_q.vld & (calc_q ^ par_i);
      miss_o.is_addr <= lat_q.is_addr;
    end
  end
endmodule

// File: rtl/pci_par_report.sv
module pci_par_report
  import pci_par_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ph_tag_t miss_i,
  input  logic    perr_en_i,
  input  logic    serr_en_i,
  input  logic    sticky_clr_i,
  output logic    perr_o,
  output logic    serr_pull_o,
  output logic    par_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_o      <= 1'b0;
      serr_pull_o <= 1'b0;
      par_err_o   <= 1'b0;
    end else begin
      perr_o      <= miss_i.vld & ~miss_i.is_addr & perr_en_i;
      serr_pull_o <= miss_i.vld &  miss_i.is_addr & serr_en_i;
      // new error wins over a same-cycle clear
      par_err_o   <= (par_err_o & ~sticky_clr_i) | miss_i.vld;
    end
  end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_vld_i,
  input  logic             phase_is_addr_i,
  input  logic             drive_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             par_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  input  logic             sticky_clr_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_o,
  output logic             serr_pull_o,
  output logic             par_err_o
);
  localparam int unsigned COV_W = AD_W + CBE_W;

  logic    calc;
  logic    send;
  ph_tag_t rx_tag;
  ph_tag_t miss;

  assign send           = phase_vld_i & drive_i;
  assign rx_tag.vld     = phase_vld_i & ~drive_i;
  assign rx_tag.is_addr = phase_is_addr_i;

  pci_par_tree #(.W(COV_W), .LANE_W(LANE_W)) u_tree (
    .data_i ({cbe_i, ad_i}),
    .par_o  (calc)
  );

  pci_par_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .send_i   (send),
    .calc_i   (calc),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  pci_par_rx u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (rx_tag),
    .calc_i (calc),
    .par_i  (par_i),
    .miss_o (miss)
  );

  pci_par_report u_rep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_i       (miss),
    .perr_en_i    (perr_en_i),
    .serr_en_i    (serr_en_i),
    .sticky_clr_i (sticky_clr_i),
    .perr_o       (perr_o),
    .serr_pull_o  (serr_pull_o),
    .par_err_o    (par_err_o)
  );
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        phase_vld_i,
  input logic        drive_i,
  input logic [31:0] ad_i,
  input logic [3:0]  cbe_i,
  input logic        perr_en_i,
  input logic        serr_en_i,
  input logic        sticky_clr_i,
  input logic        par_o,
  input logic        par_oe_o,
  input logic        perr_o,
  input logic        serr_pull_o,
  input logic        par_err_o
);
  assert_gen_par_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_vld_i && drive_i) |=> (par_oe_o && par_o == ^{$past(cbe_i), $past(ad_i)}));

  assert_gen_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_vld_i && drive_i) |=> (!par_oe_o && !par_o));

  assert_err_split_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({perr_o, serr_pull_o}));

  assert_perr_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perr_o) |-> $past(perr_en_i));

  assert_serr_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serr_pull_o) |-> $past(serr_en_i));

  assert_sticky_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o || serr_pull_o) |-> par_err_o);

  assert_sticky_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(par_err_o) |-> $past(sticky_clr_i));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R10: assert (!par_o && !par_oe_o && !perr_o && !serr_pull_o && !par_err_o);
    end
  end
endmodule

bind pci_parity_unit pci_par_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .phase_vld_i  (phase_vld_i),
  .drive_i      (drive_i),
  .ad_i         (ad_i),
  .cbe_i        (cbe_i),
  .perr_en_i    (perr_en_i),
  .serr_en_i    (serr_en_i),
  .sticky_clr_i (sticky_clr_i),
  .par_o        (par_o),
  .par_oe_o     (par_oe_o),
  .perr_o       (perr_o),
  .serr_pull_o  (serr_pull_o),
  .par_err_o    (par_err_o)
);

// File: tb/sim_pci_parity_unit.sv
`timescale 1ns/1ps
module sim_pci_parity_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, is_addr = 1'b0, drv = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        par_in = 1'b0, perr_en = 1'b0, serr_en = 1'b0, clr = 1'b0;
  logic        par_o, par_oe, perr, serr, sticky;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pci_parity_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_vld_i(vld), .phase_is_addr_i(is_addr),
    .drive_i(drv), .ad_i(ad), .cbe_i(cbe), .par_i(par_in), .perr_en_i(perr_en),
    .serr_en_i(serr_en), .sticky_clr_i(clr), .par_o(par_o), .par_oe_o(par_oe),
    .perr_o(perr), .serr_pull_o(serr), .par_err_o(sticky)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
    logic p = 1'b0;
    for (int i = 0; i < 32; i++) p ^= a[i];
    for (int i = 0; i < 4; i++) p ^= c[i];
    return p;
  endfunction

  task automatic idle();
    vld = 0; drv = 0; is_addr = 0; clr = 0; par_in = 0;
  endtask

  // R10
  task automatic t_reset();
    @(negedge clk);
    check("R10 reset outputs", {3'b0, par_o, par_oe, perr, serr, sticky}, 8'h00);
  endtask

  // R1 / R2
  task automatic t_gen(input logic [31:0] a, input logic [3:0] c);
    @(negedge clk);
    vld = 1; drv = 1; is_addr = 0; ad = a; cbe = c; par_in = ~even_par(a, c);
    @(negedge clk);
    idle();
    check("R1 par_oe", {7'b0, par_oe}, 8'h01);
    check("R1 par value", {7'b0, par_o}, {7'b0, even_par(a, c)});
    @(negedge clk);
    check("R2 par released", {6'b0, par_oe, par_o}, 8'h00);
  endtask

  // R3-R6: received phase, optional corruption
  task automatic t_rx(input string req, input logic addr, input logic [31:0] a,
                      input logic [3:0] c, input logic bad, input logic pe, input logic se);
    logic miss_p, miss_s;
    perr_en = pe; serr_en = se;
    @(negedge clk);
    vld = 1; drv = 0; is_addr = addr; ad = a; cbe = c;
    @(negedge clk);
    idle();
    par_in = even_par(a, c) ^ bad;
    check({req, " R2 no drive on receive"}, {7'b0, par_oe}, 8'h00);
    @(negedge clk);
    par_in = 0;
    check({req, " R3 not early"}, {6'b0, perr, serr}, 8'h00);
    @(negedge clk);
    miss_p = bad & ~addr & pe;
    miss_s = bad & addr & se;
    check({req, " R4 perr"}, {7'b0, perr}, {7'b0, miss_p});
    check({req, " R5 serr"}, {7'b0, serr}, {7'b0, miss_s});
    check({req, " R8 sticky"}, {7'b0, sticky}, {7'b0, bad});
    @(negedge clk);
    check({req, " R3 one cycle"}, {6'b0, perr, serr}, 8'h00);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    check("R8 clear", {7'b0, sticky}, 8'h00);
  endtask

  // R7: own phases are not checked
  task automatic t_own();
    perr_en = 1; serr_en = 1;
    @(negedge clk);
    vld = 1; drv = 1; is_addr = 0; ad = 32'h1234_5678; cbe = 4'h3;
    @(negedge clk);
    idle();
    par_in = ~even_par(32'h1234_5678, 4'h3);
    @(negedge clk);
    par_in = 0;
    @(negedge clk);
    check("R7 own phase perr", {6'b0, perr, serr}, 8'h00);
    check("R7 own phase sticky", {7'b0, sticky}, 8'h00);
  endtask

  // R9: consecutive received data phases, first bad, second good, third bad
  task automatic t_b2b();
    perr_en = 1; serr_en = 1;
    @(negedge clk);
    vld = 1; drv = 0; is_addr = 0; ad = 32'hA5A5_0001; cbe = 4'h0;
    @(negedge clk);
    par_in = ~even_par(32'hA5A5_0001, 4'h0);
    ad = 32'h0F0F_F0F0; cbe = 4'hF;
    @(negedge clk);
    par_in = even_par(32'h0F0F_F0F0, 4'hF);
    ad = 32'hFFFF_FFFF; cbe = 4'hE;
    @(negedge clk);
    vld = 0;
    par_in = ~even_par(32'hFFFF_FFFF, 4'hE);
    check("R9 first error", {7'b0, perr}, 8'h01);
    @(negedge clk);
    par_in = 0;
    check("R9 good phase between", {7'b0, perr}, 8'h00);
    @(negedge clk);
    check("R9 third error", {7'b0, perr}, 8'h01);
    @(negedge clk);
    check("R9 ends", {7'b0, perr}, 8'h00);
  endtask

  // R8: set wins over same-cycle clear
  task automatic t_set_wins();
    perr_en = 0; serr_en = 0;
    @(negedge clk);
    vld = 1; drv = 0; is_addr = 1; ad = 32'h8000_0000; cbe = 4'h6;
    @(negedge clk);
    idle();
    par_in = ~even_par(32'h8000_0000, 4'h6);
    @(negedge clk);
    par_in = 0;
    clr = 1;
    @(negedge clk);
    clr = 0;
    check("R8 set wins over clear", {7'b0, sticky}, 8'h01);
    check("R5 serr gated off", {7'b0, serr}, 8'h00);
  endtask

  initial begin
    idle();
    #1;
    check("R10 during reset", {3'b0, par_o, par_oe, perr, serr, sticky}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gen(32'h0000_0000, 4'h0);
    t_gen(32'hFFFF_FFFF, 4'hF);
    t_gen(32'h0000_0001, 4'h0);
    t_gen(32'hDEAD_BEEF, 4'h7);
    t_rx("good data", 1'b0, 32'h1357_9BDF, 4'h2, 1'b0, 1'b1, 1'b1);
    t_rx("good addr", 1'b1, 32'h0000_0100, 4'h6, 1'b0, 1'b1, 1'b1);
    t_rx("bad data", 1'b0, 32'hCAFE_0001, 4'h0, 1'b1, 1'b1, 1'b1);
    t_clear();
    t_rx("bad addr", 1'b1, 32'h0000_0400, 4'hA, 1'b1, 1'b1, 1'b1);
    t_clear();
    t_rx("bad data gated", 1'b0, 32'h7777_0000, 4'h1, 1'b1, 1'b0, 1'b1);
    t_clear();
    t_rx("bad addr gated", 1'b1, 32'h0000_0800, 4'hB, 1'b1, 1'b1, 1'b0);
    t_clear();
    t_own();
    t_b2b();
    t_clear();
    t_set_wins();
    t_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule